// File: doc/BRIEF.md
# Word DMA from Staging Buffer into Wave Memory Bank

This block moves a run of 16-bit words out of a 16 KB staging buffer and into the 4 KB wave memory bank that is selected at the moment. A single start pulse hands over the word count and the current values of two address registers. The source register is a byte pointer into the buffer. The destination register counts in 4-byte units inside the bank. The block issues one buffer read per cycle and writes each returned word into the bank after a fixed read latency. When the last write has gone out it raises a one-cycle done flag.

Neither offset ever leaves its own word-aligned window. The source offset wraps inside 16 KB and the destination offset wraps inside 4 KB. At completion the two registers hold their advanced values, so the next burst can carry on from where this one stopped. Selecting the bank and arbitrating access to either memory are left to the surrounding logic.

Top module: `wram_word_dma`

## Requirements
- R1: After reset, busy_o, done_o, rd_en_o and wr_en_o are 0, and src_reg_o and dst_reg_o are 0.
- R2: The first read address is src_reg_i AND 0x3FFE. Each following read address is the previous one plus 2, masked with 0x3FFE, so it wraps from 0x3FFE to 0x0000.
- R3: The first write address is (dst_reg_i shifted left by 2) AND 0xFFE. Each following write address is the previous one plus 2, masked with 0xFFE, so it wraps from 0xFFE to 0x000.
- R4: Each word is written unchanged, with no byte swap. The data is what rd_data_i carried RD_LAT cycles (default 1) after the matching read.
- R5: A transfer of N words makes exactly N reads on N consecutive cycles and exactly N writes, in order.
- R6: done_o is high for one cycle, in the cycle that follows the last write. With RD_LAT = 1, done_o is seen N+2 clock edges after start_i is first sampled, counting the start edge as 1.
- R7: A start with a word count of 0 raises done_o on the start edge itself and makes no read and no write.
- R8: When done_o is high, src_reg_o equals the src_reg_i given at start plus 2*N, modulo 2^16. In the same cycle, dst_reg_o equals the dst_reg_i given at start plus floor(N/2), modulo 2^16.
- R9: start_i is ignored while busy_o is high. It changes neither the ongoing write sequence nor the final register values.
- R10: src_reg_o and dst_reg_o hold steady from the cycle after the start edge until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; sampled only while idle |
| words_i | input | 16 | Number of words to move |
| src_reg_i | input | 16 | Source register value taken at start |
| dst_reg_i | input | 16 | Destination register value taken at start (4-byte units) |
| rd_en_o | output | 1 | Buffer read strobe |
| rd_addr_o | output | 14 | Buffer byte address, word aligned |
| rd_data_i | input | 16 | Buffer read data, valid RD_LAT cycles after the strobe |
| wr_en_o | output | 1 | Bank write strobe |
| wr_addr_o | output | 12 | Bank byte address, word aligned |
| wr_data_o | output | 16 | Bank write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion flag |
| src_reg_o | output | 16 | Current source register |
| dst_reg_o | output | 16 | Current destination register |

## Verification
The done-pulse property is written on the assumption that a zero-length start never lands in the same cycle as a completion. The bench always leaves at least one idle cycle between bursts, so that case does not arise. The assertions also assume that rd_data_i obeys the fixed read latency. The bench buffer model returns a word computed from the address exactly one cycle after each strobe, which keeps to that assumption. The bench stays close to exhaustive on burst lengths 0 to 9. It crosses them with buffer and bank start points that sit on a wrap boundary, and it adds long bursts that wrap each window completely.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  // one beat travelling through the read latency
  typedef struct packed {
    logic vld;
    logic last;
  } wdma_beat_t;
endpackage

// File: rtl/wdma_ofs_ctr.sv
module wdma_ofs_ctr #(
  parameter int AW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  output logic [AW-1:0] ofs_o
);
  logic [AW-1:0] ofs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ofs_q <= '0;
    else if (load_i) ofs_q <= base_i;
    else if (step_i) ofs_q <= ofs_q + AW'(2);  // natural wrap inside window
  end

  assign ofs_o = ofs_q;

  AST_OFS_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) && !$past(base_i[0]) |-> !ofs_o[0]);  // R2
endmodule

// File: rtl/wdma_lat_pipe.sv
module wdma_lat_pipe #(
  parameter int LAT = 1,
  parameter int W   = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else if (i == 0) stg_q[i] <= d_i;
      else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg_q[LAT-1];
endmodule

// File: rtl/wram_word_dma.sv
module wram_word_dma
  import wdma_pkg::*;
#(
  parameter int SRC_AW    = 14,
  parameter int DST_AW    = 12,
  parameter int REG_W     = 16,
  parameter int DST_SHIFT = 2,
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 16,
  parameter int RD_LAT    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  words_i,
  input  logic [REG_W-1:0]  src_reg_i,
  input  logic [REG_W-1:0]  dst_reg_i,
  output logic              rd_en_o,
  output logic [SRC_AW-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [DST_AW-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [REG_W-1:0]  src_reg_o,
  output logic [REG_W-1:0]  dst_reg_o
);
  localparam logic [SRC_AW-1:0] SRC_MASK = {{(SRC_AW-1){1'b1}}, 1'b0};
  localparam logic [DST_AW-1:0] DST_MASK = {{(DST_AW-1){1'b1}}, 1'b0};
  localparam int BEAT_W = $bits(wdma_beat_t);

  logic              busy_q, issuing_q, done_q;
  logic [CNT_W-1:0]  remain_q, words_q;
  logic [REG_W-1:0]  src_q, dst_q;
  logic              start_ok, last_issue;
  logic [SRC_AW-1:0] src_base;
  logic [DST_AW-1:0] dst_base;
  wdma_beat_t        beat_in, beat_out;

  assign start_ok   = start_i && !busy_q;
  assign src_base   = src_reg_i[SRC_AW-1:0] & SRC_MASK;
  assign dst_base   = DST_AW'(dst_reg_i << DST_SHIFT) & DST_MASK;
  assign last_issue = issuing_q && (remain_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      issuing_q <= 1'b0;
      done_q    <= 1'b0;
      remain_q  <= '0;
      words_q   <= '0;
      src_q     <= '0;
      dst_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        words_q <= words_i;
        src_q   <= src_reg_i;
        dst_q   <= dst_reg_i;
        if (words_i == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q    <= 1'b1;
          issuing_q <= 1'b1;
          remain_q  <= words_i;
        end
      end else if (busy_q) begin
        if (issuing_q) begin
          remain_q <= remain_q - CNT_W'(1);
          if (last_issue) issuing_q <= 1'b0;
        end
        if (beat_out.vld && beat_out.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          src_q  <= src_q + REG_W'({words_q, 1'b0});
          dst_q  <= dst_q + REG_W'(words_q >> 1);
        end
      end
    end
  end

  wdma_ofs_ctr #(.AW(SRC_AW)) u_src_ctr (
    .clk_i, .rst_ni, .load_i(start_ok), .base_i(src_base),
    .step_i(issuing_q), .ofs_o(rd_addr_o)
  );

  wdma_ofs_ctr #(.AW(DST_AW)) u_dst_ctr (
    .clk_i, .rst_ni, .load_i(start_ok), .base_i(dst_base),
    .step_i(beat_out.vld), .ofs_o(wr_addr_o)
  );

  assign beat_in = '{vld: issuing_q, last: last_issue};

  wdma_lat_pipe #(.LAT(RD_LAT), .W(BEAT_W)) u_lat (
    .clk_i, .rst_ni, .d_i(beat_in), .q_o(beat_out)
  );

  assign rd_en_o   = issuing_q;
  assign wr_en_o   = beat_out.vld;
  assign wr_data_o = rd_data_i;  // byte order kept
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign src_reg_o = src_q;
  assign dst_reg_o = dst_q;

  AST_RD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o && $past(rd_en_o) |-> rd_addr_o == SRC_AW'($past(rd_addr_o) + SRC_AW'(2)));  // R2
  AST_WR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && $past(wr_en_o) |-> wr_addr_o == DST_AW'($past(wr_addr_o) + DST_AW'(2)));  // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o || $past(start_i));  // R6
  AST_NO_WR_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !wr_en_o);  // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_en_o && !wr_en_o);  // R7
  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(src_reg_o) && $stable(dst_reg_o));  // R10
endmodule

// File: tb/wram_word_dma_tb_top.sv
`timescale 1ns/1ps
module wram_word_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] words = '0, src_reg = '0, dst_reg = '0;
  logic        rd_en, wr_en, busy, done;
  logic [13:0] rd_addr;
  logic [11:0] wr_addr;
  logic [15:0] rd_data = '0, wr_data, src_o, dst_o;

  int tests = 0, fails = 0, cyc = 0;
  int wr_k = 0, rd_k = 0;
  logic [13:0] exp_src0;
  logic [11:0] exp_dst0;
  logic        prev_done = 1'b0;

  always #10 clk = ~clk;

  wram_word_dma dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .words_i(words),
    .src_reg_i(src_reg), .dst_reg_i(dst_reg),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .busy_o(busy), .done_o(done), .src_reg_o(src_o), .dst_reg_o(dst_o)
  );

  function automatic logic [15:0] buf_word(logic [13:0] a);
    return {a, 2'b01} ^ 16'hA55A;
  endfunction

  // buffer model, one-cycle latency
  always @(posedge clk) if (rd_en) rd_data <= buf_word(rd_addr);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en) begin
        chk("R2", rd_addr, (exp_src0 + 14'(2*rd_k)) & 14'h3FFE);
        rd_k++;
      end
      if (wr_en) begin
        chk("R3", wr_addr, (exp_dst0 + 12'(2*wr_k)) & 12'hFFE);
        chk("R4", wr_data, buf_word((exp_src0 + 14'(2*wr_k)) & 14'h3FFE));
        wr_k++;
      end
      if (done && prev_done) chk("R6 pulse", 1, 0);
    end
    prev_done = done;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_xfer(int n, logic [15:0] s, logic [15:0] d, bit interfere);
    int lat;
    exp_src0 = s[13:0] & 14'h3FFE;
    exp_dst0 = 12'(d << 2) & 12'hFFE;
    wr_k = 0; rd_k = 0;
    @(negedge clk);
    start = 1'b1; words = 16'(n); src_reg = s; dst_reg = d;
    @(negedge clk);
    start = 1'b0; lat = 1;
    if (n == 0) chk("R7 no read", rd_en, 0);
    while (!done) begin
      if (interfere && lat == 2) begin  // R9 start while busy
        start = 1'b1; words = 16'd3; src_reg = 16'h0100; dst_reg = 16'h0040;
      end else start = 1'b0;
      chk("R10 hold", {src_o, dst_o}, {s, d});
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(n == 0 ? "R7 latency" : "R6 latency", lat, (n == 0) ? 1 : n + 2);
    chk("R8 src", src_o, 16'(s + 2*n));
    chk("R8 dst", dst_o, 16'(d + n/2));
    @(negedge clk);
    chk("R5 writes", wr_k, n);
    chk("R5 reads", rd_k, n);
    chk(interfere ? "R9 idle" : "R5 idle", {busy, wr_en, rd_en}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {busy, done, rd_en, wr_en, src_o, dst_o}, 0);
    rst_n = 1'b1;
    for (int n = 0; n < 10; n++) begin
      run_xfer(n, 16'h1234, 16'h0010, 0);
      run_xfer(n, 16'h3FFC, 16'h03FF, 0);   // both windows wrap
      run_xfer(n, 16'hFFFB, 16'hFFFE, 0);   // register overflow, odd src
      run_xfer(n, 16'h0001, 16'h7C01, 0);
    end
    run_xfer(5, 16'h2000, 16'h0123, 1);
    run_xfer(9, 16'h3FF0, 16'h03FE, 1);
    run_xfer(2100, 16'h0400, 16'h0200, 0);  // full bank wrap
    run_xfer(8200, 16'h3F00, 16'h0001, 0);  // full buffer wrap
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule